// File: doc/BRIEF.md
# Register Pointer with Indexed Bank

This block is the addressing core that sits behind a byte-oriented serial slave. A front end that has already decoded the bit-level protocol passes transaction-level events to it: a transaction start with a direction flag, then a stream of bytes, each marked by a one-cycle strobe, and an optional stop. In a write transaction the first byte loads the register pointer and the bytes after it are data. A read transaction has no address byte and carries on from wherever the pointer was left. After every data byte the core decides whether the pointer moves on to the next register or stays where it is.

Most registers sit outside the block. For these the core presents the pointer, the write byte and a write or read strobe, and it passes the external read value straight back to the front end. Two register addresses are handled inside the core. Address 0x60 holds an index into a 200-byte general storage bank, and address 0x61 is the data window into that bank. Every byte moved through the window advances the index by one, and the index wraps after the last byte. A read at address 0x60 also returns bank bytes and moves the index in the same way.

The control is a four-state machine. `ST_IDLE` means no transaction is open. `ST_ADDR` means a write transaction is waiting for its address byte. `ST_WDATA` and `ST_RDATA` carry the data bytes of a write and a read. A start with the write flag moves any state to `ST_ADDR`, and a start with the read flag moves any state to `ST_RDATA`. An accepted byte in `ST_ADDR` moves to `ST_WDATA`. A stop with no start moves any state to `ST_IDLE`.

Top module: `reg_pointer_core`

## Requirements
- R1: After reset the pointer is 0x00, the bank index is 0, every bank byte is 0, the state is idle and both external strobes are low.
- R2: In a write transaction, the first accepted byte after the start loads the pointer from its low 7 bits (bit 7 is ignored). That byte raises no write strobe.
- R3: A read transaction begins at the current pointer value, without an address byte.
- R4: After each accepted data byte, in either direction, the pointer increases by one if it addresses an ordinary register.
- R5: The pointer does not change after data bytes at 0x29, 0x2D, 0x4F, 0x60, 0x61 or 0x7F. Every byte of the access goes to that same register.
- R6: For an ordinary register, a write data byte raises `ext_we_o` in the strobe cycle, with `ext_addr_o` equal to the pointer and `ext_wdata_o` equal to the byte. During a read, `rd_data_o` follows `ext_rdata_i`, and consuming the byte raises `ext_re_o`.
- R7: A data byte written at 0x60 loads the bank index with the byte value modulo 200. For example, 255 loads 55 and 203 loads 3.
- R8: A data byte written at 0x61 is stored at the current bank index, and the index then advances by one. The index wraps from 199 to 0.
- R9: While the pointer is 0x60 or 0x61 in a read transaction, `rd_data_o` shows the bank byte at the index, and each consumed byte advances the index by one with the same wrap. Neither external strobe is raised at these two addresses.
- R10: Byte strobes with no open transaction (after reset or after a stop) change no pointer, index or bank state and raise no strobe.
- R11: A start that arrives in the same cycle as a byte strobe takes priority. That byte is dropped: no strobe is raised and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transaction start pulse |
| rw_i | input | 1 | Direction sampled with start: 1 write, 0 read |
| stop_i | input | 1 | Transaction end pulse |
| byte_valid_i | input | 1 | Byte strobe: write byte present or read byte consumed |
| wdata_i | input | 8 | Write byte (address or data) |
| rd_data_o | output | 8 | Read byte for the current pointer |
| ext_addr_o | output | 7 | Current register pointer |
| ext_wdata_o | output | 8 | Write data to external registers |
| ext_we_o | output | 1 | External register write strobe |
| ext_re_o | output | 1 | External register read strobe |
| ext_rdata_i | input | 8 | External register read value |

## Verification
Two things can fall in the same cycle: opening a new transaction and accepting a byte of the open one. The bench provokes this by raising a read start together with a write byte strobe while the pointer sits on an ordinary register. It then checks that no write strobe appears in that cycle and that the following read is served from the same, unadvanced address. A second overlap happens inside the bank: storing a byte at index 199 and wrapping the index to 0 occur on one edge. The bench judges this by reading back the bytes written at both ends of the bank.

// File: rtl/rp_pkg.sv
package rp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } rp_state_e;
endpackage

// File: rtl/rp_hold_decode.sv
// Flags pointer values at which auto-increment is suppressed.
module rp_hold_decode #(
    parameter int ADDR_W = 7,
    parameter int N_WIDE = 5,
    parameter logic [N_WIDE*ADDR_W-1:0] WIDE_LIST = {7'h7F, 7'h61, 7'h4F, 7'h2D, 7'h29},
    parameter logic [ADDR_W-1:0] INDEX_REG = 7'h60
) (
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              hold_o
);
    logic [N_WIDE:0] hit;

    assign hit[N_WIDE] = (ptr_i == INDEX_REG);

    for (genvar k = 0; k < N_WIDE; k++) begin : g_cmp
        assign hit[k] = (ptr_i == WIDE_LIST[k*ADDR_W +: ADDR_W]);
    end

    assign hold_o = |hit;
endmodule

// File: rtl/rp_bank.sv
// General storage bank with its own wrapping byte index.
module rp_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 200,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] reduced;
    logic [IDX_W-1:0]  idx_next;

    assign reduced  = load_val_i % DATA_W'(DEPTH);
    assign idx_next = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load_i) begin
            idx <= IDX_W'(reduced);
        end else if (step_i) begin
            idx <= idx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_i) begin
            mem[idx] <= wdata_i;
        end
    end

    assign rdata_o = mem[idx];
    assign idx_o   = idx;
endmodule

// File: rtl/reg_pointer_core.sv
module reg_pointer_core #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int BANK_DEPTH = 200,
    parameter logic [ADDR_W-1:0] INDEX_REG = 7'h60,
    parameter logic [ADDR_W-1:0] DATA_REG  = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rw_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] ext_addr_o,
    output logic [DATA_W-1:0] ext_wdata_o,
    output logic              ext_we_o,
    output logic              ext_re_o,
    input  logic [DATA_W-1:0] ext_rdata_i
);
    import rp_pkg::*;
    localparam int IDX_W = $clog2(BANK_DEPTH);

    rp_state_e state, state_nxt;
    logic [ADDR_W-1:0] ptr;
    logic accept, in_data, addr_load, data_byte;
    logic hold, on_index, on_data, on_bank;
    logic bank_wr, idx_load, idx_step;
    logic [DATA_W-1:0] bank_rdata;
    logic [IDX_W-1:0]  bank_idx;

    // A start or stop in the same cycle swallows the byte strobe.
    assign accept    = byte_valid_i && !start_i && !stop_i;
    assign in_data   = (state == ST_WDATA) || (state == ST_RDATA);
    assign addr_load = accept && (state == ST_ADDR);
    assign data_byte = accept && in_data;
    assign on_index  = (ptr == INDEX_REG);
    assign on_data   = (ptr == DATA_REG);
    assign on_bank   = on_index || on_data;

    rp_hold_decode #(
        .ADDR_W(ADDR_W),
        .INDEX_REG(INDEX_REG)
    ) i_hold (
        .ptr_i (ptr),
        .hold_o(hold)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        if (start_i) begin
            state_nxt = rw_i ? ST_ADDR : ST_RDATA;
        end else if (stop_i) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_ADDR:  if (accept) state_nxt = ST_WDATA;
                ST_WDATA: state_nxt = ST_WDATA;
                ST_RDATA: state_nxt = ST_RDATA;
            endcase
        end
    end

    // Outputs and bank controls
    always_comb begin
        ext_we_o  = 1'b0;
        ext_re_o  = 1'b0;
        bank_wr   = 1'b0;
        idx_load  = 1'b0;
        idx_step  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR: ;
            ST_WDATA: begin
                ext_we_o = data_byte && !on_bank;
                bank_wr  = data_byte && on_data;
                idx_load = data_byte && on_index;
                idx_step = data_byte && on_data;
            end
            ST_RDATA: begin
                ext_re_o = data_byte && !on_bank;
                idx_step = data_byte && on_bank;
            end
        endcase
        rd_data_o = on_bank ? bank_rdata : ext_rdata_i;
    end

    // Register pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (addr_load) begin
            ptr <= wdata_i[ADDR_W-1:0];
        end else if (data_byte && !hold) begin
            ptr <= ptr + 1'b1;
        end
    end

    rp_bank #(
        .DATA_W(DATA_W),
        .DEPTH (BANK_DEPTH)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (idx_load),
        .load_val_i(wdata_i),
        .step_i    (idx_step),
        .wr_i      (bank_wr),
        .wdata_i   (wdata_i),
        .rdata_o   (bank_rdata),
        .idx_o     (bank_idx)
    );

    assign ext_addr_o  = ptr;
    assign ext_wdata_o = wdata_i;
endmodule

// File: rtl/reg_pointer_chk.sv
module reg_pointer_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             byte_valid_i,
    input logic [6:0]       ext_addr_o,
    input logic             ext_we_o,
    input logic             ext_re_o,
    input logic [7:0]       bank_idx,
    input rp_pkg::rp_state_e state
);
    import rp_pkg::*;

    logic taken, fixed_reg, bank_reg;
    assign taken     = byte_valid_i && !start_i && !stop_i &&
                       (state == ST_WDATA || state == ST_RDATA);
    assign bank_reg  = (ext_addr_o == 7'h60) || (ext_addr_o == 7'h61);
    assign fixed_reg = bank_reg || (ext_addr_o == 7'h29) || (ext_addr_o == 7'h2D) ||
                       (ext_addr_o == 7'h4F) || (ext_addr_o == 7'h7F);

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !fixed_reg |=> ext_addr_o == $past(ext_addr_o) + 7'd1);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        taken && fixed_reg |=> $stable(ext_addr_o));

    a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        taken && ext_addr_o == 7'h61 |=>
        bank_idx == (($past(bank_idx) == 8'd199) ? 8'd0 : $past(bank_idx) + 8'd1));

    a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        bank_idx < 8'd200);

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_we_o, ext_re_o}));

    a_r9_bank_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        bank_reg |-> !ext_we_o && !ext_re_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !ext_we_o && !ext_re_o);

    a_r11_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !ext_we_o && !ext_re_o);

    a_r11_start_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> $stable(ext_addr_o));
endmodule

bind reg_pointer_core reg_pointer_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_valid_i(byte_valid_i),
    .ext_addr_o  (ext_addr_o),
    .ext_we_o    (ext_we_o),
    .ext_re_o    (ext_re_o),
    .bank_idx    (bank_idx),
    .state       (state)
);

// File: tb/test_reg_pointer_core.sv
`timescale 1ns/1ps
module test_reg_pointer_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, rw_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rd_data_o, ext_wdata_o, ext_rdata_i;
    logic [6:0] ext_addr_o;
    logic       ext_we_o, ext_re_o;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    // External register model: each register reads as its address plus 0x40.
    assign ext_rdata_i = {1'b0, ext_addr_o} + 8'h40;

    reg_pointer_core i_reg_pointer_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rw_i(rw_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o),
        .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o), .ext_we_o(ext_we_o),
        .ext_re_o(ext_re_o), .ext_rdata_i(ext_rdata_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_txn(input logic wr);
        @(negedge clk); start_i = 1'b1; rw_i = wr;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic stop_txn();
        @(negedge clk); stop_i = 1'b1;
        @(posedge clk); #1 stop_i = 1'b0;
    endtask

    task automatic send_ext(input logic [7:0] b, input logic [6:0] addr, input string tag);
        @(negedge clk); byte_valid_i = 1'b1; wdata_i = b; #1;
        chk({tag, " we"}, ext_we_o, 1'b1);
        chk({tag, " addr"}, ext_addr_o, addr);
        chk({tag, " wdata"}, ext_wdata_o, b);
        @(posedge clk); #1 byte_valid_i = 1'b0;
    endtask

    task automatic send_quiet(input logic [7:0] b, input string tag);
        @(negedge clk); byte_valid_i = 1'b1; wdata_i = b; #1;
        chk({tag, " no we"}, {ext_we_o, ext_re_o}, 2'b00);
        @(posedge clk); #1 byte_valid_i = 1'b0;
    endtask

    task automatic recv_ext(input logic [6:0] addr, input string tag);
        @(negedge clk); #1;
        chk({tag, " addr"}, ext_addr_o, addr);
        chk({tag, " rdata"}, rd_data_o, {1'b0, addr} + 8'h40);
        byte_valid_i = 1'b1; #1;
        chk({tag, " re"}, ext_re_o, 1'b1);
        @(posedge clk); #1 byte_valid_i = 1'b0;
    endtask

    task automatic recv_bank(input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        chk({tag, " bank data"}, rd_data_o, exp);
        byte_valid_i = 1'b1; #1;
        chk({tag, " no re"}, {ext_we_o, ext_re_o}, 2'b00);
        @(posedge clk); #1 byte_valid_i = 1'b0;
    endtask

    task automatic set_index(input logic [7:0] v);
        start_txn(1'b1); send_quiet(8'h60, "R2 addr 0x60"); send_quiet(v, "R7 index load");
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 pointer at reset", ext_addr_o, 7'h00);
        chk("R1 strobes at reset", {ext_we_o, ext_re_o}, 2'b00);
        send_quiet(8'h33, "R10 strobe after reset");
        start_txn(1'b0);
        recv_ext(7'h00, "R1 R3 read from zero");
    endtask

    task automatic t_increment();
        start_txn(1'b1);
        send_quiet(8'h10, "R2 address byte");
        send_ext(8'hA1, 7'h10, "R6 write 0x10");
        send_ext(8'hA2, 7'h11, "R4 write 0x11");
        send_ext(8'hA3, 7'h12, "R4 write 0x12");
        start_txn(1'b0);
        recv_ext(7'h13, "R3 read continues");
        recv_ext(7'h14, "R4 read step");
    endtask

    task automatic t_hold();
        start_txn(1'b1);
        send_quiet(8'h29, "R2 address 0x29");
        send_ext(8'h11, 7'h29, "R5 first byte 0x29");
        send_ext(8'h22, 7'h29, "R5 second byte 0x29");
        start_txn(1'b0);
        recv_ext(7'h29, "R5 read 0x29 a");
        recv_ext(7'h29, "R5 read 0x29 b");
        start_txn(1'b1);
        send_quiet(8'hCF, "R2 address bit7 set");
        send_ext(8'h44, 7'h4F, "R2 R5 0x4F");
        send_ext(8'h45, 7'h4F, "R5 0x4F again");
        start_txn(1'b1);
        send_quiet(8'hFF, "R2 address 0xFF");
        send_ext(8'h55, 7'h7F, "R5 0x7F");
        send_ext(8'h56, 7'h7F, "R5 0x7F again");
    endtask

    task automatic t_bank();
        set_index(8'd5);
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61");
        send_quiet(8'hB1, "R8 store 5");
        send_quiet(8'hB2, "R8 store 6");
        send_quiet(8'hB3, "R8 store 7");
        set_index(8'd5);
        start_txn(1'b0);
        recv_bank(8'hB1, "R9 read via 0x60 idx5");
        recv_bank(8'hB2, "R9 read idx6");
        recv_bank(8'hB3, "R9 read idx7");
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61"); stop_txn();
        start_txn(1'b0);
        recv_bank(8'h00, "R1 R9 untouched byte idx8");
    endtask

    task automatic t_modulo();
        set_index(8'hFF);
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61"); send_quiet(8'h77, "R7 store at 55");
        set_index(8'd55);
        start_txn(1'b0); recv_bank(8'h77, "R7 255 maps to 55");
        set_index(8'd203);
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61"); send_quiet(8'h3C, "R7 store at 3");
        set_index(8'd3);
        start_txn(1'b0); recv_bank(8'h3C, "R7 203 maps to 3");
    endtask

    task automatic t_wrap();
        set_index(8'd199);
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61");
        send_quiet(8'hD1, "R8 store 199");
        send_quiet(8'hD2, "R8 store after wrap");
        set_index(8'd199);
        start_txn(1'b0);
        recv_bank(8'hD1, "R8 byte at 199");
        recv_bank(8'hD2, "R8 R9 byte at 0 after wrap");
    endtask

    task automatic t_idle();
        set_index(8'd20);
        start_txn(1'b1); send_quiet(8'h61, "R2 addr 0x61"); stop_txn();
        send_quiet(8'h5A, "R10 stray byte on bank");
        send_quiet(8'h5B, "R10 stray byte on bank 2");
        start_txn(1'b0);
        recv_bank(8'h00, "R10 bank and index untouched");
        start_txn(1'b1); send_quiet(8'h20, "R2 addr 0x20"); stop_txn();
        send_quiet(8'h01, "R10 stray byte");
        start_txn(1'b0);
        recv_ext(7'h20, "R10 pointer untouched");
    endtask

    task automatic t_collide();
        start_txn(1'b1); send_quiet(8'h30, "R2 addr 0x30");
        @(negedge clk);
        start_i = 1'b1; rw_i = 1'b0; byte_valid_i = 1'b1; wdata_i = 8'h99; #1;
        chk("R11 no write with start", {ext_we_o, ext_re_o}, 2'b00);
        @(posedge clk); #1 start_i = 1'b0; byte_valid_i = 1'b0;
        recv_ext(7'h30, "R11 pointer not advanced");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_increment();
        t_hold();
        t_bank();
        t_modulo();
        t_wrap();
        t_idle();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule